// File: doc/BRIEF.md
# Cache ECC Fault Injection Controller

This block lets privileged software turn cache ECC checking on and ask for a single deliberate error to be planted in either the tag store or the data store of a cache line, chosen by physical address. Software talks to it through two 64-bit registers on a simple one-access-per-cycle register bus. The first register carries the check enable, an inject trigger, a target select, and two read-only fields: a progress status and a failure reason. The second register holds the physical address of the line to corrupt.

When the trigger is written, the block checks the request in that same cycle. If checking is off or the target code is reserved, it goes straight to the error status and sends nothing to the cache. Otherwise it freezes the target and address, offers them to the cache on a valid/ready port, and waits for a response. The response says whether the line was found. A hit ends in the injected status and a miss ends in the error status. Both final states are cleared to idle by the next read of the control register, so software polls until it sees a final code.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, the control register (offset 0x0) and the address register (offset 0x8) both read as zero, `chk_enable` is 0 and `inj_valid` is 0.
- R2: In the control register, bit 0 is the check enable and drives `chk_enable`. Bits 3:2 are the target and read back as written on every control write. Bits 6:4 are the status and bits 9:7 are the reason. Bits 63:10 read as 0. The address register keeps the low PA_W bits written and reads 0 above them.
- R3: Bit 1 of the control register is the inject trigger. Writing it as 1 requests an injection, and it always reads back as 0.
- R4: A trigger written from idle with bit 0 of the same write equal to 0 sets status 7 (error) and reason 0 on the next cycle, and no cache request is made. This check takes priority over the target check.
- R5: A trigger written from idle with checking enabled and target 1 or 3 (reserved) sets status 7 and reason 1, and no cache request is made.
- R6: A trigger written from idle with checking enabled and target 0 (tag store) or 2 (data store) sets status 1 (working). It raises `inj_valid` with `inj_target` and `inj_addr` frozen from that moment, and holds them until the cycle `inj_ready` is high.
- R7: After the request is accepted, a response with `inj_rsp_hit`=1 sets status 2 (injected).
- R8: After the request is accepted, a response with `inj_rsp_hit`=0 sets status 7 with reason 2. The reason field keeps the code of the latest failure until the next failure.
- R9: A read of the control register while the status is 2 or 7 returns that status and sets the status to 0 (idle) on the next cycle. A read while the status is working leaves the status unchanged.
- R10: A trigger written while the status is working, injected or error is ignored. The status and the frozen request stay as they were, while the enable and target fields still take the written values.
- R11: The status only ever holds the codes 0, 1, 2 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | OFS_W | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for the offset presented (combinational) |
| chk_enable | output | 1 | ECC check enable to the cache |
| inj_valid | output | 1 | Injection request valid |
| inj_ready | input | 1 | Cache accepts the request |
| inj_target | output | 2 | Frozen target: 0 tag store, 2 data store |
| inj_addr | output | PA_W | Frozen physical address |
| inj_rsp_valid | input | 1 | Cache response valid |
| inj_rsp_hit | input | 1 | 1 = line present and corrupted, 0 = line absent |

## Verification
The bench goes after the ordering of the two pre-checks. A design that tested the target before the enable would report reason 1 for a disabled request with a reserved target. It also holds `inj_ready` low for random stretches and rewrites the target and address while a request is pending; a design that did not freeze the request would show the new values on the cache port. It checks that a read returns a final status and only then clears it, and that reads during working leave the status alone. It retriggers while the result is still unread; a design that accepted the trigger would lose the injected or error result or start a second request.

// File: rtl/eci_pkg.sv
package eci_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BUSY = 3'd1,
    ST_DONE = 3'd2,
    ST_FAIL = 3'd7
  } st_e;

  localparam logic [2:0] RSN_OFF  = 3'd0;
  localparam logic [2:0] RSN_TGT  = 3'd1;
  localparam logic [2:0] RSN_MISS = 3'd2;

  // Pre-check outcome for a trigger: enable is tested before the target.
  function automatic logic precheck_ok(input logic en, input logic [1:0] tgt);
    return en && !tgt[0];
  endfunction

  function automatic logic [2:0] reject_code(input logic en);
    return en ? RSN_TGT : RSN_OFF;
  endfunction

  // Control word as software sees it; the trigger bit always reads 0.
  function automatic logic [DATA_W-1:0] pack_ctrl(input logic en, input logic [1:0] tgt,
                                                  input logic [2:0] st, input logic [2:0] rsn);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0]   = en;
    w[3:2] = tgt;
    w[6:4] = st;
    w[9:7] = rsn;
    return w;
  endfunction
endpackage

// File: rtl/eci_regs.sv
module eci_regs #(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_addr,
  input  logic            wd_en,
  input  logic [1:0]      wd_tgt,
  input  logic [PA_W-1:0] wd_addr,
  output logic            en_q,
  output logic [1:0]      tgt_q,
  output logic [PA_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      tgt_q  <= 2'd0;
      addr_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wd_en;
        tgt_q <= wd_tgt;
      end
      if (wr_addr) addr_q <= wd_addr;
    end
  end
endmodule

// File: rtl/eci_fsm.sv
module eci_fsm
  import eci_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            trig_en,
  input  logic [1:0]      trig_tgt,
  input  logic [PA_W-1:0] addr_q,
  input  logic            rd_ctrl,
  output logic            inj_valid,
  input  logic            inj_ready,
  output logic [1:0]      inj_target,
  output logic [PA_W-1:0] inj_addr,
  input  logic            inj_rsp_valid,
  input  logic            inj_rsp_hit,
  output logic [2:0]      status,
  output logic [2:0]      reason
);
  st_e             st_q;
  logic [2:0]      rsn_q;
  logic            sent_q;
  logic [1:0]      snap_tgt;
  logic [PA_W-1:0] snap_addr;

  // Named events for the assertions
  logic accept_trig, req_fire, rsp_take, final_read;
  assign accept_trig = (st_q == ST_IDLE) && trig;
  assign req_fire    = inj_valid && inj_ready;
  assign rsp_take    = (st_q == ST_BUSY) && sent_q && inj_rsp_valid;
  assign final_read  = ((st_q == ST_DONE) || (st_q == ST_FAIL)) && rd_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rsn_q     <= RSN_OFF;
      sent_q    <= 1'b0;
      snap_tgt  <= 2'd0;
      snap_addr <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (trig) begin
          if (precheck_ok(trig_en, trig_tgt)) begin
            st_q      <= ST_BUSY;
            sent_q    <= 1'b0;
            snap_tgt  <= trig_tgt;
            snap_addr <= addr_q;
          end else begin
            st_q  <= ST_FAIL;
            rsn_q <= reject_code(trig_en);
          end
        end
        ST_BUSY: begin
          if (req_fire) sent_q <= 1'b1;
          if (rsp_take) begin
            st_q <= inj_rsp_hit ? ST_DONE : ST_FAIL;
            if (!inj_rsp_hit) rsn_q <= RSN_MISS;
          end
        end
        ST_DONE, ST_FAIL: if (rd_ctrl) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign inj_valid  = (st_q == ST_BUSY) && !sent_q;
  assign inj_target = snap_tgt;
  assign inj_addr   = snap_addr;
  assign status     = st_q;
  assign reason     = rsn_q;

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && !inj_ready |=> inj_valid && $stable(inj_addr) && $stable(inj_target));
  a_r6_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> status == 3'd1);
  a_r4_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    accept_trig && !trig_en |=> status == 3'd7 && reason == 3'd0 && !inj_valid);
  a_r5_tgt_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    accept_trig && trig_en && trig_tgt[0] |=> status == 3'd7 && reason == 3'd1 && !inj_valid);
  a_r7_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd0 |=> status != 3'd2);
  a_r8_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && !inj_rsp_hit |=> status == 3'd7 && reason == 3'd2);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    final_read |=> status == 3'd0);
  a_r10_hold_final: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd2 || status == 3'd7) && !rd_ctrl |=> $stable(status));
  a_r11_legal: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd0 || status == 3'd1 || status == 3'd2 || status == 3'd7);
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
  import eci_pkg::*;
#(
  parameter int PA_W  = 48,
  parameter int OFS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [OFS_W-1:0]  bus_offset,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              chk_enable,
  output logic              inj_valid,
  input  logic              inj_ready,
  output logic [1:0]        inj_target,
  output logic [PA_W-1:0]   inj_addr,
  input  logic              inj_rsp_valid,
  input  logic              inj_rsp_hit
);
  localparam logic [OFS_W-1:0] OFS_CTRL = OFS_W'(0);
  localparam logic [OFS_W-1:0] OFS_ADDR = OFS_W'(8);

  logic sel_ctrl, sel_addr, wr_ctrl, wr_addr, rd_ctrl, trig;
  assign sel_ctrl = bus_offset == OFS_CTRL;
  assign sel_addr = bus_offset == OFS_ADDR;
  assign wr_ctrl  = bus_valid && bus_write && sel_ctrl;
  assign wr_addr  = bus_valid && bus_write && sel_addr;
  assign rd_ctrl  = bus_valid && !bus_write && sel_ctrl;
  assign trig     = wr_ctrl && bus_wdata[1];

  logic            en_q;
  logic [1:0]      tgt_q;
  logic [PA_W-1:0] addr_q;
  logic [2:0]      status, reason;

  eci_regs #(.PA_W(PA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_addr(wr_addr),
    .wd_en(bus_wdata[0]), .wd_tgt(bus_wdata[3:2]), .wd_addr(bus_wdata[PA_W-1:0]),
    .en_q(en_q), .tgt_q(tgt_q), .addr_q(addr_q)
  );

  eci_fsm #(.PA_W(PA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_en(bus_wdata[0]),
    .trig_tgt(bus_wdata[3:2]), .addr_q(addr_q), .rd_ctrl(rd_ctrl),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_target(inj_target),
    .inj_addr(inj_addr), .inj_rsp_valid(inj_rsp_valid), .inj_rsp_hit(inj_rsp_hit),
    .status(status), .reason(reason)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)      bus_rdata = pack_ctrl(en_q, tgt_q, status, reason);
    else if (sel_addr) bus_rdata = {{(DATA_W-PA_W){1'b0}}, addr_q};
  end

  assign chk_enable = en_q;

  a_r2_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> chk_enable == $past(bus_wdata[0]));
  a_r3_trigger_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |-> bus_rdata[1] == 1'b0);
endmodule

// File: tb/sim_ecc_inject_ctrl.sv
module sim_ecc_inject_ctrl;
  localparam int PA_W = 48;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [3:0] bus_offset = 0;
  logic [63:0] bus_wdata = 0, bus_rdata;
  logic chk_enable, inj_valid, inj_ready = 0, inj_rsp_valid = 0, inj_rsp_hit = 0;
  logic [1:0] inj_target;
  logic [PA_W-1:0] inj_addr;

  ecc_inject_ctrl #(.PA_W(PA_W), .OFS_W(4)) u0 (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // bench model
  logic m_en = 0; logic [1:0] m_tgt = 0; logic [2:0] m_st = 0, m_rs = 0;
  logic [PA_W-1:0] m_addr = 0;

  function automatic logic [63:0] exp_ctrl();
    return {54'd0, m_rs, m_st, m_tgt, 1'b0, m_en};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] o, input logic [63:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_offset = o; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [3:0] o, output logic [63:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_offset = o; #1 d = bus_rdata;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic read_ctrl(input string req);
    logic [63:0] d;
    bus_rd(4'h0, d);
    chk(req, d, exp_ctrl());
    if (m_st == 3'd2 || m_st == 3'd7) m_st = 3'd0;
  endtask

  // writes a control word with the trigger set; updates the model
  task automatic trigger(input logic en, input logic [1:0] tgt);
    logic [63:0] d;
    logic was_idle;
    d = {$urandom, $urandom};
    d[0] = en; d[1] = 1'b1; d[3:2] = tgt;
    was_idle = (m_st == 3'd0);
    bus_wr(4'h0, d);
    m_en = en; m_tgt = tgt;
    if (was_idle) begin
      if (!en)         begin m_st = 3'd7; m_rs = 3'd0; end
      else if (tgt[0]) begin m_st = 3'd7; m_rs = 3'd1; end
      else             m_st = 3'd1;
    end
    chk("R2 chk_enable", 64'(chk_enable), 64'(en));
  endtask

  task automatic set_addr(input logic [63:0] a);
    logic [63:0] d;
    bus_wr(4'h8, a);
    bus_rd(4'h8, d);
    chk("R2 addr readback", d, {16'd0, a[PA_W-1:0]});
  endtask

  // full run; retrig=1 also rewrites fields during the pending request (R10)
  task automatic run_one(input logic en, input logic [1:0] tgt, input logic hit,
                         input int dly, input bit retrig);
    logic [PA_W-1:0] a;
    set_addr({$urandom, $urandom});
    a = u_addr_shadow;
    trigger(en, tgt);
    if (m_st == 3'd7) begin
      chk(en ? "R5 no request" : "R4 no request", 64'(inj_valid), 64'd0);
      read_ctrl(en ? "R5 reason 1" : "R4 reason 0");
      read_ctrl("R9 cleared to idle");
      return;
    end
    if (retrig) begin
      set_addr({$urandom, $urandom});
      trigger(1'b1, 2'd2 - tgt);
      read_ctrl("R10 trigger ignored while working");
    end
    for (int i = 0; i < dly; i++) begin
      chk("R6 valid held", 64'(inj_valid), 64'd1);
      chk("R6 addr frozen", 64'(inj_addr), 64'(a));
      chk("R6 target frozen", 64'(inj_target), 64'(tgt));
      @(negedge clk);
    end
    chk("R6 valid before accept", 64'(inj_valid), 64'd1);
    inj_ready = 1;
    @(negedge clk); inj_ready = 0;
    chk("R6 valid drops after accept", 64'(inj_valid), 64'd0);
    read_ctrl("R9 read while working keeps status");
    @(negedge clk); inj_rsp_valid = 1; inj_rsp_hit = hit;
    @(negedge clk); inj_rsp_valid = 0;
    if (hit) m_st = 3'd2; else begin m_st = 3'd7; m_rs = 3'd2; end
    read_ctrl(hit ? "R7 injected" : "R8 miss reason 2");
    read_ctrl("R9 cleared to idle");
  endtask

  // bench-side copy of the last address written, taken from its own stimulus
  logic [PA_W-1:0] u_addr_shadow;
  always @(posedge clk) if (bus_valid && bus_write && bus_offset == 4'h8)
    u_addr_shadow <= bus_wdata[PA_W-1:0];

  initial begin
    logic [63:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    bus_rd(4'h0, d); chk("R1 ctrl reset", d, 64'd0);
    bus_rd(4'h8, d); chk("R1 addr reset", d, 64'd0);
    chk("R1 no request", 64'(inj_valid), 64'd0);
    chk("R1 enable off", 64'(chk_enable), 64'd0);
    // R2/R3 plain write without trigger, status fields not writable
    bus_wr(4'h0, 64'hFFFF_FFFF_FFFF_FFFD);
    m_en = 1; m_tgt = 2'd3;
    read_ctrl("R2 R3 field layout");
    // directed corner cases
    run_one(1'b0, 2'd1, 1'b1, 0, 0);   // R4: enable check before target check
    run_one(1'b1, 2'd3, 1'b1, 0, 0);   // R5
    run_one(1'b1, 2'd0, 1'b1, 3, 1);   // R6 R10
    run_one(1'b1, 2'd2, 1'b0, 0, 0);   // R8
    // R10: retrigger while injected result is unread
    run_one_hold();
    // random
    for (int k = 0; k < 40; k++)
      run_one($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
              $urandom_range(0, 4), $urandom_range(0, 3) == 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run_one_hold();
    set_addr(64'h0000_1234_5678_9AB0);
    trigger(1'b1, 2'd0);
    inj_ready = 1; @(negedge clk); inj_ready = 0;
    @(negedge clk); inj_rsp_valid = 1; inj_rsp_hit = 1;
    @(negedge clk); inj_rsp_valid = 0;
    m_st = 3'd2;
    trigger(1'b1, 2'd2);
    chk("R10 no new request", 64'(inj_valid), 64'd0);
    read_ctrl("R10 injected kept through retrigger");
    read_ctrl("R9 cleared after retrigger case");
  endtask

  initial begin
    #(1_500_000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule